// File: doc/BRIEF.md
# Receive-Only Byte Request Packer

This block runs one receive-only serial transfer on request. Software writes a byte count once. From then on the block asks an external shift engine for bytes, one at a time, and never supplies transmit data. It collects the bytes into 32-bit words and hands each finished word to an external receive FIFO, together with a small count of how many of its bytes are valid. The shift engine and the FIFO storage are outside the block. The block drives only the request and push sides of those two interfaces.

Word width is not configurable here: every word carries four bytes, except the last word of a transfer. When the requested count is not a multiple of four, that last word holds only the remaining bytes, packed toward the least significant end. A readable to-do counter tracks how many bytes have not yet been pushed. A single-cycle completion pulse marks the push that empties it.

Top module: `rx_only_packer`

## Requirements
- R1: After reset, `byte_req`, `push_o` and `rx_done` are low and `todo` reads 0.
- R2: A cycle with `req_wr` high loads `req_bytes` into `todo`, which is visible on the next cycle, and the block then requests bytes while `todo` is nonzero. A count of 0 requests nothing, pushes nothing and raises no completion pulse.
- R3: Every pushed word except the final partial one carries exactly four bytes, with `push_bv` = 4.
- R4: Within a word, bytes are ordered by arrival. The earliest byte sits in the most significant valid lane, at bit offset (push_bv-1)*8, and the latest byte sits in bits 7:0.
- R5: When the count leaves a remainder of 1 to 3 bytes, the final word carries `push_bv` equal to that remainder. Its bytes are right-aligned and its unused upper lanes are zero.
- R6: `todo` falls by `push_bv` in the same cycle that `push_o` presents a word, and changes at no other time except a request write.
- R7: `rx_done` is high for exactly one cycle per nonzero request. That cycle is the one in which the final word is pushed and `todo` reads 0.
- R8: While `fifo_full` is high at a word boundary, `byte_req` stays low, so no bytes are lost. `push_o` is never high while `fifo_full` is high.
- R9: With no reads from the FIFO, a request of four times the FIFO depth in bytes completes and fills the FIFO exactly, with no push into a full FIFO.
- R10: Strobes on `byte_stb` in cycles where `byte_req` is low are ignored and do not appear in any pushed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Request write strobe; starts or restarts a transfer |
| req_bytes | input | 16 | Byte count loaded by a request write |
| byte_req | output | 1 | Block will accept a byte from the shift engine this cycle |
| byte_stb | input | 1 | Shift engine presents a received byte |
| byte_data | input | 8 | Received byte |
| fifo_full | input | 1 | Receive FIFO cannot take another word |
| push_o | output | 1 | Write strobe toward the receive FIFO |
| push_word | output | 32 | Packed word, right-aligned when partial |
| push_bv | output | 3 | Valid byte count of the pushed word, 1 to 4 in binary |
| todo | output | 16 | Bytes of the current request not yet pushed |
| rx_done | output | 1 | One-cycle pulse on the final push of a request |

## Verification
A wrong lane counter shows up within the first word. The byte order or the `push_bv` value of the first push comes out wrong, or a partial word appears early, before `todo` has reached 0. A wrong `todo` value appears on the very push where it goes astray: the captured `todo` then disagrees with the bytes delivered so far, and the completion pulse either comes on the wrong push or never comes. A flaw in the full-FIFO gating appears when a word starts while `fifo_full` is high, or when a push lands while `fifo_full` is high.

// File: rtl/rxo_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the receive-only packer.
package rxo_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxo_todo_ctr.sv
`timescale 1ns/1ps
// Module: rxo_todo_ctr
// Holds the count of bytes not yet pushed for the current request.
// Loads on a request write. Otherwise it drops by the size of each pushed word.
// Assumes the decrement amount never exceeds the current count.
module rxo_todo_ctr #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned AMT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic [AMT_W-1:0] dec_amt_i,
    output logic [CNT_W-1:0] todo_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] todo_q;
    logic             done_q;
    logic [CNT_W-1:0] amt_c;

    // Widen the word size to the counter width.
    assign amt_c = CNT_W'(dec_amt_i);

    // Load on request, shrink on each word push, pulse when the count empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            todo_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i) begin
                todo_q <= load_val_i;
            end else if (dec_i) begin
                todo_q <= todo_q - amt_c;
                done_q <= (todo_q == amt_c);
            end
        end
    end

    assign todo_o = todo_q;
    assign busy_o = (todo_q != '0);
    assign done_o = done_q;

    // R6: a push never removes more bytes than remain.
    a_r6_dec_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (amt_c != '0 && amt_c <= todo_q));
    // R7: the completion pulse only appears with an empty count.
    a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (todo_o == '0));
endmodule

// File: rtl/rxo_byte_packer.sv
`timescale 1ns/1ps
// Module: rxo_byte_packer
// Shifts accepted bytes into a word register, earliest byte at the top.
// It closes the word after WORD_BYTES bytes, or when the byte count
// reaches the remaining to-do count.
// It issues a registered push with the valid-byte count, and asks the
// to-do counter to drop by that count in the same edge.
// Assumes WORD_BYTES >= 2 and that todo_i is nonzero whenever accept_i is high.
module rxo_byte_packer
    import rxo_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned LANE_W    = $clog2(WORD_BYTES),
    localparam int unsigned BV_W      = $clog2(WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              accept_i,
    input  byte_t             byte_i,
    input  logic [CNT_W-1:0]  todo_i,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o,
    output logic [BV_W-1:0]   bv_o,
    output logic              dec_o,
    output logic [BV_W-1:0]   dec_amt_o,
    output logic              lane_idle_o
);
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] acc_q;
    logic              push_q;
    logic [WORD_W-1:0] word_q;
    logic [BV_W-1:0]   bv_q;
    logic [CNT_W-1:0]  fill_c;
    logic              last_c;
    logic [WORD_W-1:0] merged_c;

    // Bytes in the word once the current byte is added.
    assign fill_c = CNT_W'(lane_q) + CNT_W'(1);

    // The word closes when it is full or when it holds every remaining byte.
    assign last_c = (fill_c == CNT_W'(WORD_BYTES)) || (fill_c == todo_i);

    // Shift the new byte in at the bottom.
    assign merged_c = {acc_q[WORD_W-BYTE_W-1:0], byte_i};

    // Tell the counter how many bytes leave with this word.
    assign dec_o     = accept_i && last_c;
    assign dec_amt_o = BV_W'(fill_c);

    // Gather bytes into a word and emit the closed word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            acc_q  <= '0;
            push_q <= 1'b0;
            word_q <= '0;
            bv_q   <= '0;
        end else begin
            push_q <= 1'b0;
            if (flush_i) begin
                lane_q <= '0;
                acc_q  <= '0;
            end else if (accept_i) begin
                if (last_c) begin
                    push_q <= 1'b1;
                    word_q <= merged_c;
                    bv_q   <= BV_W'(fill_c);
                    lane_q <= '0;
                    acc_q  <= '0;
                end else begin
                    acc_q  <= merged_c;
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end

    assign push_o      = push_q;
    assign word_o      = word_q;
    assign bv_o        = bv_q;
    assign lane_idle_o = (lane_q == '0);

    // R5: a pushed word always reports between one and WORD_BYTES valid bytes.
    a_r5_bv_range: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (bv_o != '0 && bv_o <= BV_W'(WORD_BYTES)));
    // R5: a short word is only ever the final word of a request.
    a_r5_partial_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && bv_o != BV_W'(WORD_BYTES)) |-> (todo_i == '0));
    // R3: while a word is being filled, at least one more byte is still owed.
    a_r3_open_word_owed: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q != '0) |-> (todo_i > CNT_W'(lane_q)));
endmodule

// File: rtl/rxo_flow_gate.sv
`timescale 1ns/1ps
// Module: rxo_flow_gate
// Decides whether the shift engine may deliver a byte this cycle.
// A new word starts only when the FIFO has room and no push is still in
// flight. Once a word has started, it runs to its end, because only this
// block fills the FIFO.
// Assumes the FIFO full flag covers every push up to the previous edge.
module rxo_flow_gate (
    input  logic busy_i,
    input  logic hold_i,
    input  logic lane_idle_i,
    input  logic fifo_full_i,
    input  logic push_pend_i,
    output logic byte_req_o
);
    logic boundary_block_c;

    // A word boundary is blocked by a full FIFO or by a push not yet counted in it.
    assign boundary_block_c = lane_idle_i && (fifo_full_i || push_pend_i);

    // Request while bytes are owed, no request write is in progress, and the boundary is clear.
    assign byte_req_o = busy_i && !hold_i && !boundary_block_c;
endmodule

// File: rtl/rx_only_packer.sv
`timescale 1ns/1ps
// Module: rx_only_packer (top)
// Runs one receive-only transfer per request write.
// It requests bytes from an external shift engine and packs them into
// WORD_BYTES-wide words, the final word right-aligned.
// It pushes each word with its valid-byte count to an external FIFO.
// A to-do count can be read back, and a one-cycle pulse marks completion.
// Assumes the engine delivers a byte only as a strobe, and that the FIFO
// full flag reflects every push up to the previous edge.
module rx_only_packer
    import rxo_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
    localparam int unsigned BV_W      = $clog2(WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              byte_req,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              fifo_full,
    output logic              push_o,
    output logic [WORD_W-1:0] push_word,
    output logic [BV_W-1:0]   push_bv,
    output logic [CNT_W-1:0]  todo,
    output logic              rx_done
);
    logic            busy_w;
    logic            lane_idle_w;
    logic            dec_w;
    logic [BV_W-1:0] dec_amt_w;
    logic            accept_w;

    // A byte is taken only when the engine strobes in a requested cycle.
    assign accept_w = byte_stb && byte_req;

    rxo_todo_ctr #(
        .CNT_W (CNT_W),
        .AMT_W (BV_W)
    ) u_todo (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (req_wr),
        .load_val_i (req_bytes),
        .dec_i      (dec_w),
        .dec_amt_i  (dec_amt_w),
        .todo_o     (todo),
        .busy_o     (busy_w),
        .done_o     (rx_done)
    );

    rxo_byte_packer #(
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (req_wr),
        .accept_i    (accept_w),
        .byte_i      (byte_data),
        .todo_i      (todo),
        .push_o      (push_o),
        .word_o      (push_word),
        .bv_o        (push_bv),
        .dec_o       (dec_w),
        .dec_amt_o   (dec_amt_w),
        .lane_idle_o (lane_idle_w)
    );

    rxo_flow_gate u_gate (
        .busy_i      (busy_w),
        .hold_i      (req_wr),
        .lane_idle_i (lane_idle_w),
        .fifo_full_i (fifo_full),
        .push_pend_i (push_o),
        .byte_req_o  (byte_req)
    );

    // R8: the FIFO never sees a write while it reports full.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !fifo_full);
    // R2: with nothing owed, no byte is requested.
    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (todo == '0) |-> !byte_req);
    // R6: the count changes only with a push or a request write.
    a_r6_todo_moves_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |=> (push_o || $stable(todo)));
    // R7: the completion pulse coincides with a push.
    a_r7_done_with_push: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> push_o);
endmodule

// File: tb/rx_only_packer_tb.sv
`timescale 1ns/1ps
// Directed bench for rx_only_packer, with a FIFO occupancy model and a byte-engine model.
module rx_only_packer_tb;
    localparam int FIFO_DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_bytes = '0;
    logic        byte_req;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        fifo_full;
    logic        push_o;
    logic [31:0] push_word;
    logic [2:0]  push_bv;
    logic [15:0] todo;
    logic        rx_done;

    int chk = 0;
    int fails = 0;

    // FIFO model
    int   occ = 0;
    logic pop_en = 1'b1;
    logic fifo_clr = 1'b0;

    // push recorder
    logic        rec = 1'b0;
    logic [31:0] mw [64];
    logic [2:0]  mb [64];
    logic [15:0] mt [64];
    logic        md [64];
    int npush = 0;
    int ndone = 0;
    int novf = 0;

    always #2 clk = ~clk;

    rx_only_packer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (req_wr),
        .req_bytes (req_bytes),
        .byte_req  (byte_req),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .fifo_full (fifo_full),
        .push_o    (push_o),
        .push_word (push_word),
        .push_bv   (push_bv),
        .todo      (todo),
        .rx_done   (rx_done)
    );

    assign fifo_full = (occ >= FIFO_DEPTH);

    always @(posedge clk) begin
        if (fifo_clr) occ <= 0;
        else occ <= occ + (push_o ? 1 : 0) - ((pop_en && occ > 0) ? 1 : 0);
    end

    always @(negedge clk) begin
        if (push_o && fifo_full) novf = novf + 1;
        if (rec && push_o && npush < 64) begin
            mw[npush] = push_word;
            mb[npush] = push_bv;
            mt[npush] = todo;
            md[npush] = rx_done;
            npush = npush + 1;
        end
        if (rec && rx_done) ndone = ndone + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int base, input int start, input int cnt);
        logic [31:0] w = '0;
        for (int i = 0; i < cnt; i++) w = (w << 8) | 32'((base + start + i) & 8'hFF);
        return w;
    endfunction

    task automatic start_rec();
        npush = 0; ndone = 0; rec = 1'b1;
    endtask

    task automatic issue(input int n);
        @(negedge clk);
        req_wr = 1'b1; req_bytes = 16'(n);
        @(negedge clk);
        req_wr = 1'b0;
        #1 check(todo == 16'(n), "R2 todo load", 32'(todo), 32'(n));
    endtask

    task automatic feed(input int n, input int base);
        int idx = 0;
        int guard = 0;
        while (idx < n && guard < 4000) begin
            @(negedge clk);
            byte_stb = 1'b1; byte_data = 8'((base + idx) & 8'hFF);
            #1;
            if (byte_req) idx++;
            guard++;
        end
        @(negedge clk);
        byte_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_result(input int n, input int base, input string tag);
        int words = (n + 3) / 4;
        check(npush == words, {tag, " push count"}, 32'(npush), 32'(words));
        for (int k = 0; k < words && k < npush; k++) begin
            int cnt = (n - 4 * k >= 4) ? 4 : n - 4 * k;
            check(mw[k] == exp_word(base, 4 * k, cnt), {tag, " R4 R5 word"}, mw[k], exp_word(base, 4 * k, cnt));
            check(mb[k] == 3'(cnt), {tag, " R3 R5 bv"}, 32'(mb[k]), 32'(cnt));
            check(mt[k] == 16'(n - 4 * k - cnt), {tag, " R6 todo"}, 32'(mt[k]), 32'(n - 4 * k - cnt));
            check(md[k] == (k == words - 1), {tag, " R7 done place"}, 32'(md[k]), 32'(k == words - 1));
        end
        check(ndone == 1, {tag, " R7 done count"}, 32'(ndone), 32'd1);
        check(todo == 16'd0, {tag, " R6 final todo"}, 32'(todo), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(byte_req == 1'b0, "R1 byte_req", 32'(byte_req), 32'd0);
        check(push_o == 1'b0, "R1 push", 32'(push_o), 32'd0);
        check(rx_done == 1'b0, "R1 done", 32'(rx_done), 32'd0);
        check(todo == 16'd0, "R1 todo", 32'(todo), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_transfer(input int n, input int base, input string tag);
        start_rec();
        issue(n);
        feed(n, base);
        rec = 1'b0;
        check_result(n, base, tag);
    endtask

    task automatic t_zero();
        start_rec();
        issue(0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_stb = 1'b1; byte_data = 8'h55;
            #1 check(byte_req == 1'b0, "R2 zero count no req", 32'(byte_req), 32'd0);
        end
        @(negedge clk);
        byte_stb = 1'b0;
        repeat (2) @(negedge clk);
        rec = 1'b0;
        check(npush == 0, "R2 zero count no push", 32'(npush), 32'd0);
        check(ndone == 0, "R2 zero count no done", 32'(ndone), 32'd0);
    endtask

    task automatic t_ignore();
        start_rec();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_stb = 1'b1; byte_data = 8'hEE;
        end
        @(negedge clk);
        byte_stb = 1'b0;
        check(npush == 0, "R10 idle strobes no push", 32'(npush), 32'd0);
        issue(4);
        feed(4, 8'h10);
        rec = 1'b0;
        check_result(4, 8'h10, "R10");
    endtask

    task automatic t_stall();
        @(negedge clk);
        pop_en = 1'b0; fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        novf = 0;
        t_transfer(4 * FIFO_DEPTH, 8'h40, "R9");
        check(occ == FIFO_DEPTH, "R9 fifo filled", 32'(occ), 32'(FIFO_DEPTH));
        start_rec();
        issue(4);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            byte_stb = 1'b1; byte_data = 8'(8'h80 + 0);
            #1 check(byte_req == 1'b0, "R8 stalled while full", 32'(byte_req), 32'd0);
        end
        check(npush == 0, "R8 no push while full", 32'(npush), 32'd0);
        pop_en = 1'b1;
        feed(4, 8'h80);
        rec = 1'b0;
        check_result(4, 8'h80, "R8");
        check(novf == 0, "R8 R9 overflow pushes", 32'(novf), 32'd0);
    endtask

    initial begin
        #400000;
        fails++; chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", chk - fails, chk);
        $finish;
    end

    initial begin
        t_reset();
        t_transfer(8, 8'hA0, "R3 full words");
        t_transfer(7, 8'h01, "R5 rem3");
        t_transfer(5, 8'h20, "R5 rem1");
        t_transfer(2, 8'hC3, "R5 short only");
        t_transfer(12, 8'h60, "R4 three words");
        t_zero();
        t_ignore();
        t_stall();
        $display("%0d/%0d checks passed", chk - fails, chk);
        $finish;
    end
endmodule